// File: doc/BRIEF.md
# Interrupt flag and enable controller

This block collects event conditions from a small peripheral into sticky flag bits and raises one combined interrupt line. The two low sources watch a PLL. The lock-lost source fires when the lock status drops while the PLL is enabled. The lock-timer source fires once a programmed number of cycles has passed after the PLL enable rises. The remaining sources are generic single-cycle event pulses from the rest of the peripheral.

Software reaches the block through a small register bus with a combinational read path. It reads the flags, clears them by writing ones, and changes the enable mask through two addresses. One address sets enable bits and the other clears them, so an enable can change without a read-modify-write. Address decoding on `bus_addr` is 0 for the flag register, 1 for enable-set, 2 for enable-clear, and 3 for an unused slot that reads as zero.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags and all enables are zero and `irq_o` is low.
- R2: A high `ev_i[i]` at a clock edge sets flag bit 2+i. Flags are sticky: a flag stays set until it is cleared by a write.
- R3: A write to address 1 sets each enable bit whose data bit is one and leaves the bits written as zero unchanged. A read of address 1 or of address 2 returns the current enable mask.
- R4: A write to address 2 clears each enable bit whose data bit is one and leaves the other bits unchanged.
- R5: A write to address 0 clears each flag whose data bit is one. Zero bits have no effect. If a source event arrives in the same cycle as the clear of its flag, the flag ends up set.
- R6: `irq_o` is high exactly when at least one source has both its flag and its enable set.
- R7: Flag bit 0 (lock lost) is set when `pll_lock_i` goes from one to zero while `pll_en_i` is high. A falling edge while `pll_en_i` is low, or a rising edge, does not set it.
- R8: Flag bit 1 (lock timer) is set at the clock edge L+1 edges after the edge that first samples `pll_en_i` high, where L is the value on `lock_time_i`.
- R9: The lock timer fires only once per rise of `pll_en_i`. If `pll_en_i` drops before the timeout, no flag is raised. A new rise of `pll_en_i` restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | NUM_EXT | Generic event pulses for sources 2 and up |
| pll_en_i | input | 1 | PLL enable (running) status |
| pll_lock_i | input | 1 | PLL lock status |
| lock_time_i | input | TIMER_W | Programmed lock-timer delay in cycles |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | NUM_EXT+2 | Write data, one bit per source |
| bus_rdata | output | NUM_EXT+2 | Read data, one bit per source |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The lock-lost property assumes that the PLL enable and the lock status are synchronous to `clk` and that a lock-status edge seen in the first cycle after reset is not counted. The bench keeps the lock input low through reset and changes it only on falling clock edges. The persistence checks on flags and on the interrupt line assume that no event or bus write other than the one observed changes them. The bench therefore drives every bus write, event pulse and PLL transition from the falling edge as one-cycle operations, and it never overlaps them except in the deliberate set-versus-clear case.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int NUM_EXT = 2,
  parameter int TIMER_W = 4,
  localparam int NSRC = NUM_EXT + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ev_i,
  input  logic               pll_en_i,
  input  logic               pll_lock_i,
  input  logic [TIMER_W-1:0] lock_time_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [NSRC-1:0]    bus_wdata,
  output logic [NSRC-1:0]    bus_rdata,
  output logic               irq_o
);

  localparam logic [1:0] A_FLAG = 2'd0;
  localparam logic [1:0] A_ESET = 2'd1;
  localparam logic [1:0] A_ECLR = 2'd2;

  logic [NSRC-1:0]    flag_q, en_q;
  logic [TIMER_W-1:0] cnt_q;
  logic               lock_q, pllen_q, run_q;

  wire wr_en = bus_sel & bus_wr;
  wire [NSRC-1:0] flag_clr = (wr_en && bus_addr == A_FLAG) ? bus_wdata : '0;
  wire [NSRC-1:0] en_set   = (wr_en && bus_addr == A_ESET) ? bus_wdata : '0;
  wire [NSRC-1:0] en_clr   = (wr_en && bus_addr == A_ECLR) ? bus_wdata : '0;

  wire lock_lost = pll_en_i & lock_q & ~pll_lock_i;
  wire pll_start = pll_en_i & ~pllen_q;
  wire timeout   = run_q & pll_en_i & (cnt_q == lock_time_i);
  wire [NSRC-1:0] ev_set = {ev_i, timeout, lock_lost};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      pllen_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      lock_q  <= pll_lock_i;
      pllen_q <= pll_en_i;
      if (pll_start) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (!pll_en_i || timeout) run_q <= 1'b0;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | ev_set;
      en_q   <= (en_q | en_set) & ~en_clr;
    end
  end

  always_comb begin
    case (bus_addr)
      A_FLAG:         bus_rdata = flag_q;
      A_ESET, A_ECLR: bus_rdata = en_q;
      default:        bus_rdata = '0;
    endcase
  end

  assign irq_o = |(flag_q & en_q);

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pll_en_i,
  input logic            pll_lock_i,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] flag_q,
  input logic [NSRC-1:0] en_q,
  input logic            irq_o
);

  wire wr_any = bus_sel && bus_wr;
  wire [NSRC-1:0] m_fclr = (wr_any && bus_addr == 2'd0) ? bus_wdata : '0;
  wire [NSRC-1:0] m_eset = (wr_any && bus_addr == 2'd1) ? bus_wdata : '0;
  wire [NSRC-1:0] m_eclr = (wr_any && bus_addr == 2'd2) ? bus_wdata : '0;

  p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eset != '0) |=> ((en_q & $past(m_eset)) == $past(m_eset)));

  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eclr != '0) |=> ((en_q & $past(m_eclr)) == '0));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q & ~m_fclr) & ~flag_q) == '0));

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_any) |=> irq_o);

  p_lock_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en_i && !pll_lock_i && $past(pll_lock_i) && $past(rst_n)) |=> flag_q[0]);

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_en_i(pll_en_i), .pll_lock_i(pll_lock_i),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .flag_q(flag_q), .en_q(en_q), .irq_o(irq_o)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  localparam int NE = 2;
  localparam int TW = 4;
  localparam int NS = NE + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] ev_i = '0;
  logic pll_en_i = 1'b0, pll_lock_i = 1'b0;
  logic [TW-1:0] lock_time_i = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [NS-1:0] bus_wdata = '0;
  logic [NS-1:0] bus_rdata;
  logic irq_o;

  int n_chk = 0, n_bad = 0;
  logic [NS-1:0] rv;

  always #4 clk = ~clk;

  irq_flag_ctrl #(.NUM_EXT(NE), .TIMER_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .pll_en_i(pll_en_i),
    .pll_lock_i(pll_lock_i), .lock_time_i(lock_time_i), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [NS-1:0] d);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_all_flags();
    lock_time_i = '0; pll_lock_i = 1'b1; pll_en_i = 1'b1;
    step();
    pll_lock_i = 1'b0; ev_i = '1;
    step();
    ev_i = '0; pll_en_i = 1'b0;
    step();
  endtask

  task automatic timer_run(input int L, input string req);
    lock_time_i = TW'(L); pll_en_i = 1'b1;
    for (int n = 1; n <= L + 2; n++) begin
      step();
      rd(2'd0, rv);
      if (n == L + 1) check(req, int'(rv[1]), 0);
      if (n == L + 2) check(req, int'(rv[1]), 1);
    end
    pll_en_i = 1'b0;
    step();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();

    // R1 reset state
    rd(2'd0, rv); check("R1 flags", int'(rv), 0);
    rd(2'd1, rv); check("R1 enables", int'(rv), 0);
    check("R1 irq", int'(irq_o), 0);

    // R3 enable set sweep, both read addresses, zero write no effect
    for (int p = 0; p < 16; p++) begin
      wr(2'd2, '1);
      wr(2'd1, NS'(p));
      rd(2'd1, rv); check("R3 set read1", int'(rv), p);
      rd(2'd2, rv); check("R3 set read2", int'(rv), p);
      wr(2'd1, '0);
      rd(2'd1, rv); check("R3 zero write", int'(rv), p);
    end

    // R4 enable clear sweep
    for (int p = 0; p < 16; p++) begin
      wr(2'd1, '1);
      wr(2'd2, NS'(p));
      rd(2'd2, rv); check("R4 clear", int'(rv), (~p) & 15);
    end
    wr(2'd2, '1);

    // R2 generic events, sticky
    ev_i = 2'b01; step(); ev_i = '0;
    rd(2'd0, rv); check("R2 ev0", int'(rv), 4'b0100);
    step(5);
    rd(2'd0, rv); check("R2 sticky", int'(rv), 4'b0100);
    ev_i = 2'b10; step(); ev_i = '0;
    rd(2'd0, rv); check("R2 ev1", int'(rv), 4'b1100);

    // R5 clear by one, zeros no effect, set wins
    wr(2'd0, '0);
    rd(2'd0, rv); check("R5 zero clear", int'(rv), 4'b1100);
    wr(2'd0, 4'b0100);
    rd(2'd0, rv); check("R5 clear", int'(rv), 4'b1000);
    ev_i = 2'b10;
    wr(2'd0, 4'b1000);
    ev_i = '0;
    rd(2'd0, rv); check("R5 set wins", int'(rv), 4'b1000);
    wr(2'd0, '1);
    rd(2'd0, rv); check("R5 clear all", int'(rv), 0);

    // R7 lock lost
    lock_time_i = '1;
    pll_lock_i = 1'b1; step(); pll_lock_i = 1'b0; step();
    rd(2'd0, rv); check("R7 fall while disabled", int'(rv[0]), 0);
    pll_en_i = 1'b1; step();
    pll_lock_i = 1'b1; step();
    rd(2'd0, rv); check("R7 rising edge", int'(rv[0]), 0);
    pll_lock_i = 1'b0; step();
    rd(2'd0, rv); check("R7 fall while enabled", int'(rv[0]), 1);
    pll_en_i = 1'b0; step();
    wr(2'd0, '1);

    // R8 timer delay sweep
    for (int L = 0; L < 16; L++) begin
      wr(2'd0, '1);
      timer_run(L, "R8 timeout");
    end

    // R9 one shot, cancel, restart
    wr(2'd0, '1);
    lock_time_i = 4'd5; pll_en_i = 1'b1; step(10);
    rd(2'd0, rv); check("R9 fired", int'(rv[1]), 1);
    wr(2'd0, 4'b0010); step(20);
    rd(2'd0, rv); check("R9 one shot", int'(rv[1]), 0);
    pll_en_i = 1'b0; step();
    pll_en_i = 1'b1; step(3); pll_en_i = 1'b0; step(12);
    rd(2'd0, rv); check("R9 cancel", int'(rv[1]), 0);
    pll_en_i = 1'b1; step(3); pll_en_i = 1'b0; step();
    timer_run(6, "R9 restart");

    // R6 combined request over all flag and enable patterns
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 16; e++) begin
        set_all_flags();
        wr(2'd0, NS'((~f) & 15));
        wr(2'd2, '1);
        wr(2'd1, NS'(e));
        rd(2'd0, rv); check("R6 flag pattern", int'(rv), f);
        check("R6 irq", int'(irq_o), ((f & e) != 0) ? 1 : 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule